// File: doc/BRIEF.md
# Power-Fail Store/Recall Sequencer

This block runs an SRAM that has a nonvolatile shadow array through supply loss and supply return. Two supply-comparator flags come in: one says the supply is above the switch level, the other says it is above the lower reset level. Both flags pass through a two-flop synchroniser before the state machine uses them.

When the supply comes up from reset, or after a deep dip below the reset level, the block runs a timed recall. The recall copies the shadow array into the SRAM. When the supply drops below the switch level, the block waits through a short grace window so that an SRAM cycle already in flight can finish. After that window it runs a timed store into the shadow array, but only if some SRAM write has happened since the last store or recall.

A shallow dip, where the supply never falls below the reset level, does not trigger a recall when the supply returns. The block drives level strobes to the array control for the recall and for the store, a busy flag, a write-inhibit signal for the SRAM, and the dirty flag. All durations are parameters counted in clock cycles.

Top module: `pwr_fail_seq`

## Requirements
- R1: While reset is held, and after it is released with both supply flags low, `recall_o`, `store_o`, `busy_o` and `dirty_o` are 0 and `write_inhibit_o` is 1.
- R2: A supply flag change is acted on at the third rising clock edge after it. After reset, a rise of `above_switch_i` starts a recall: `recall_o` and `busy_o` stay high for exactly RECALL_CYC cycles. After that, `write_inhibit_o` goes low.
- R3: A one-cycle `sram_write_strobe_i` taken while the block is ready for writes (`write_inhibit_o` low) sets `dirty_o` on the next cycle.
- R4: A write strobe has no effect on `dirty_o` in any other state: reset wait, recall, grace window, store, or low-supply idle.
- R5: When `above_switch_i` falls while the block is ready and `dirty_o` is 1, a grace window of GRACE_CYC cycles follows. Then `store_o` and `busy_o` stay high for exactly STORE_CYC cycles.
- R6: When the supply falls while `dirty_o` is 0, no store is run.
- R7: `dirty_o` is 0 after a store or a recall completes.
- R8: When the supply returns after a dip in which `above_reset_i` stayed 1, and any store is done, no recall runs and writes are enabled again.
- R9: When `above_reset_i` went low at any time while the supply was down, the next rise of `above_switch_i` runs a full recall of RECALL_CYC cycles.
- R10: When `above_reset_i` is already low at the end of the grace window, no store runs. `dirty_o` stays 1 until the recall that follows supply return.
- R11: `write_inhibit_o` is 1 in every state except ready. `busy_o` is high exactly while `recall_o` or `store_o` is high.
- R12: When `above_switch_i` falls during a recall, the recall is aborted. The next supply return runs a full recall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| above_switch_i | input | 1 | Comparator: supply above switch level (asynchronous) |
| above_reset_i | input | 1 | Comparator: supply above reset level (asynchronous) |
| sram_write_strobe_i | input | 1 | One-cycle pulse per SRAM write |
| recall_o | output | 1 | Shadow-to-SRAM transfer active |
| store_o | output | 1 | SRAM-to-shadow transfer active |
| busy_o | output | 1 | A nonvolatile transfer is in progress |
| write_inhibit_o | output | 1 | SRAM writes must be blocked |
| dirty_o | output | 1 | A write is pending since the last store or recall |

## Verification
A write strobe and a supply-loss flag can reach the block in the same cycle. Whether the store happens then depends on whether the state machine is still ready at the edge that captures the strobe.

The bench drops `above_switch_i` and issues a strobe 0 to 3 cycles later. Because of the synchroniser, offsets of 0 to 2 cycles must still mark the SRAM dirty and produce a store. An offset of 3 cycles lands in the grace window and must produce none. The store count observed at the ports is compared with the value computed from that offset.

// File: rtl/nvps_pkg.sv
package nvps_pkg;
  typedef enum logic [2:0] {
    ST_RESET_WAIT,
    ST_RECALL,
    ST_READY,
    ST_DRAIN,
    ST_STORE,
    ST_LOW_IDLE
  } seq_state_e;
endpackage

// File: rtl/nvps_sync.sv
module nvps_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/nvps_timer.sv
module nvps_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R5
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/nvps_dirty.sv
module nvps_dirty (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic dirty_o
);
  logic dirty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dirty_q <= 1'b0;
    else if (clr_i)  dirty_q <= 1'b0;
    else if (set_i)  dirty_q <= 1'b1;
  end

  assign dirty_o = dirty_q;

  // R3
  dirty_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> dirty_q);
  // R7
  dirty_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !dirty_q);
endmodule

// File: rtl/pwr_fail_seq.sv
module pwr_fail_seq #(
  parameter int RECALL_CYC = 55000,
  parameter int STORE_CYC  = 1000000,
  parameter int GRACE_CYC  = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic above_switch_i,
  input  logic above_reset_i,
  input  logic sram_write_strobe_i,
  output logic recall_o,
  output logic store_o,
  output logic busy_o,
  output logic write_inhibit_o,
  output logic dirty_o
);
  import nvps_pkg::*;

  localparam int MAX_A   = (RECALL_CYC > STORE_CYC) ? RECALL_CYC : STORE_CYC;
  localparam int MAX_CYC = (MAX_A > GRACE_CYC) ? MAX_A : GRACE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seq_state_e       state_q, state_d;
  logic [1:0]       flags_s;
  logic             sw_ok, rst_ok;
  logic             deep_q, deep_d;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  logic             dirty_set, dirty_clr;

  nvps_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({above_switch_i, above_reset_i}),
    .sync_o  (flags_s)
  );
  assign sw_ok  = flags_s[1];
  assign rst_ok = flags_s[0];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET_WAIT: if (sw_ok) state_d = ST_RECALL;
      ST_RECALL: begin
        if (!sw_ok)        state_d = ST_LOW_IDLE;
        else if (tmr_done) state_d = ST_READY;
      end
      ST_READY:  if (!sw_ok) state_d = ST_DRAIN;
      ST_DRAIN:  if (tmr_done) state_d = (dirty_o && rst_ok) ? ST_STORE : ST_LOW_IDLE;
      ST_STORE:  if (tmr_done) state_d = ST_LOW_IDLE;
      ST_LOW_IDLE: if (sw_ok) state_d = deep_q ? ST_RECALL : ST_READY;
      default:   state_d = ST_RESET_WAIT;
    endcase
  end

  // deep-dip flag: forces a recall on the next return
  always_comb begin
    deep_d = deep_q;
    if (state_d == ST_RECALL && state_q != ST_RECALL)
      deep_d = 1'b0;
    else if (!rst_ok || (state_q == ST_RECALL && state_d == ST_LOW_IDLE))
      deep_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RESET_WAIT;
      deep_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      deep_q  <= deep_d;
    end
  end

  always_comb begin
    tmr_load = (state_d != state_q);
    unique case (state_d)
      ST_RECALL: tmr_val = CNT_W'(RECALL_CYC - 1);
      ST_DRAIN:  tmr_val = CNT_W'(GRACE_CYC - 1);
      ST_STORE:  tmr_val = CNT_W'(STORE_CYC - 1);
      default: begin
        tmr_val  = '0;
        tmr_load = 1'b0;
      end
    endcase
  end

  nvps_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  assign dirty_set = (state_q == ST_READY) && sram_write_strobe_i;
  assign dirty_clr = ((state_q == ST_STORE) && tmr_done) ||
                     ((state_q == ST_RECALL) && (state_d == ST_READY));

  nvps_dirty u_dirty (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (dirty_set),
    .clr_i   (dirty_clr),
    .dirty_o (dirty_o)
  );

  assign recall_o        = (state_q == ST_RECALL);
  assign store_o         = (state_q == ST_STORE);
  assign busy_o          = recall_o | store_o;
  assign write_inhibit_o = (state_q != ST_READY);

  // R6
  store_needs_dirty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_o |-> dirty_o);
  // R5
  store_after_grace_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(store_o) |-> ($past(state_q) == ST_DRAIN));
  // R4
  dirty_only_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_READY) |=> !$rose(dirty_o));
  // R9
  recall_needs_deep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(recall_o) |-> $past(deep_q));
  // R11
  xfer_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({recall_o, store_o}));
endmodule

// File: tb/pwr_fail_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_fail_seq_tb_top;
  localparam int RC = 20;
  localparam int SC = 40;
  localparam int GC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw = 1'b0, rs = 1'b0, wr = 1'b0;
  logic recall_o, store_o, busy_o, write_inhibit_o, dirty_o;

  always #2.5 clk = ~clk;

  pwr_fail_seq #(.RECALL_CYC(RC), .STORE_CYC(SC), .GRACE_CYC(GC)) dut_i (
    .clk_i (clk), .rst_ni (rst_n),
    .above_switch_i (sw), .above_reset_i (rs),
    .sram_write_strobe_i (wr),
    .recall_o (recall_o), .store_o (store_o), .busy_o (busy_o),
    .write_inhibit_o (write_inhibit_o), .dirty_o (dirty_o)
  );

  int errors = 0, checks = 0;
  int rec_n, sto_n, rec_len, sto_len, rec_run, sto_run, busy_cyc;

  always @(posedge clk) begin
    #1;
    if (recall_o) rec_run++;
    else if (rec_run != 0) begin rec_len = rec_run; rec_n++; rec_run = 0; end
    if (store_o) sto_run++;
    else if (sto_run != 0) begin sto_len = sto_run; sto_n++; sto_run = 0; end
    if (busy_o) busy_cyc++;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_wr();
    wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic clr_mon();
    rec_n = 0; sto_n = 0; rec_len = 0; sto_len = 0; busy_cyc = 0;
  endtask

  function automatic int exp_store(int nw);
    return (nw > 0) ? 1 : 0;
  endfunction
  function automatic int exp_collide(int d);
    return (d <= 2) ? 1 : 0;
  endfunction

  task automatic restore(bit deep);
    clr_mon();
    rs = 1'b1; sw = 1'b1;
    step(RC + 8);
    chk("R8/R9 recall count", rec_n, deep ? 1 : 0);
    if (deep) chk("R9 recall length", rec_len, RC);
    chk("R8 writable after return", write_inhibit_o, 0);
    chk("R7 dirty after return", dirty_o, 0);
  endtask

  task automatic power_cycle(int nw, bit deep);
    chk("R11 ready not inhibited", write_inhibit_o, 0);
    for (int i = 0; i < nw; i++) begin pulse_wr(); step(1); end
    chk("R3 dirty after writes", dirty_o, exp_store(nw));
    clr_mon();
    sw = 1'b0;
    step(GC + 6);
    if (deep) rs = 1'b0;
    step(SC + 6);
    chk("R5/R6 store count", sto_n, exp_store(nw));
    if (nw > 0) chk("R5 store length", sto_len, SC);
    chk("R11 busy cycles", busy_cyc, sto_n * sto_len);
    chk("R7 dirty after store", dirty_o, 0);
    chk("R11 inhibited while down", write_inhibit_o, 1);
    restore(deep);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e));
    clr_mon(); rec_run = 0; sto_run = 0;
    step(3);
    chk("R1 inhibit in reset", write_inhibit_o, 1);
    chk("R1 busy in reset", busy_o, 0);
    rst_n = 1'b1;
    step(3);
    pulse_wr(); step(1);
    chk("R1 recall idle", recall_o, 0);
    chk("R1 store idle", store_o, 0);
    chk("R1 dirty idle", dirty_o, 0);
    chk("R1 inhibit idle", write_inhibit_o, 1);

    // power-up recall, writes during recall ignored
    clr_mon();
    sw = 1'b1; rs = 1'b1;
    step(3);
    chk("R2 recall started", recall_o, 1);
    chk("R2 busy during recall", busy_o, 1);
    pulse_wr(); step(1); pulse_wr();
    step(RC + 5);
    chk("R2 recall length", rec_len, RC);
    chk("R2 recall count", rec_n, 1);
    chk("R4 writes in recall ignored", dirty_o, 0);
    chk("R2 writable after recall", write_inhibit_o, 0);

    // writes in grace window ignored, clean drop: no store
    clr_mon();
    sw = 1'b0;
    step(4);
    chk("R11 inhibit in grace", write_inhibit_o, 1);
    pulse_wr();
    step(GC + SC);
    chk("R6 no store when clean", sto_n, 0);
    chk("R4 writes in grace ignored", dirty_o, 0);
    restore(1'b0);

    // writes during store and low idle ignored
    pulse_wr(); step(1);
    sw = 1'b0;
    step(GC + 6);
    chk("R5 store active", store_o, 1);
    pulse_wr();
    step(SC);
    pulse_wr(); step(1);
    chk("R4 writes in store/low ignored", dirty_o, 0);
    restore(1'b0);

    // collision: write strobe vs supply drop
    for (int d = 0; d < 4; d++) begin
      clr_mon();
      sw = 1'b0;
      step(d);
      pulse_wr();
      step(GC + SC + 8);
      chk("R5 collision store", sto_n, exp_collide(d));
      restore(1'b0);
    end

    // store blocked below reset level
    pulse_wr(); step(1);
    clr_mon();
    sw = 1'b0; rs = 1'b0;
    step(GC + SC + 10);
    chk("R10 store blocked", sto_n, 0);
    chk("R10 dirty kept", dirty_o, 1);
    restore(1'b1);

    // recall aborted by supply loss
    sw = 1'b0; rs = 1'b0;
    step(GC + 10);
    rs = 1'b1; sw = 1'b1;
    step(8);
    chk("R12 recall running", recall_o, 1);
    sw = 1'b0;
    step(10);
    chk("R12 recall aborted", recall_o, 0);
    restore(1'b1);

    for (int it = 0; it < 10; it++) begin
      int  nw;
      bit  dp;
      nw = $urandom_range(0, 3);
      dp = 1'($urandom_range(0, 1));
      power_cycle(nw, dp);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule